// File: doc/BRIEF.md
# Daisy-Chain Converter Readback Controller

This block is the host side of a serial link to a string of successive-approximation converters wired as a daisy chain. All converters share one convert strobe and one serial clock. Each device passes its neighbour's bits along, so the host sees a single data line. On a start request the controller first sets the serial clock to a level that picks one of two completion options. It then raises the convert strobe. Next it waits for the conversion to finish, either by counting a fixed worst-case conversion time or by watching the data line for the rising completion flag. Finally it clocks the whole chain out and returns one word per device together with a single-cycle valid strobe.

In flag mode the controller gives up if the flag does not arrive within a configurable count. It then drops the strobe and pulses a timeout output. The convert strobe stays high from the start of conversion until the final readback clock. A new start is accepted only when the controller is idle and a minimum number of cycles has passed since the previous strobe rising edge. A start that arrives at any other time is dropped.

Top module: `chain_adc_reader`

## Requirements
- R1: After reset, `cnv_o`, `sck_o`, `valid_o` and `timeout_o` are all low.
- R2: `sck_o` equals the latched `busy_mode_i` value (0 = timed wait, 1 = completion flag) in the cycle before `cnv_o` rises, and does not change across that rising edge.
- R3: In timed mode the controller waits at least `CONV_CYC` cycles after `cnv_o` rises before the first `sck_o` rising edge. It then issues exactly `NUM_DEV*WORD_W` rising edges.
- R4: In flag mode the controller starts clocking once `sdo_i` is seen high and issues exactly `NUM_DEV*WORD_W+1` rising edges. The bit sampled at the first edge is discarded.
- R5: The first data bit received is the MSB of `words_o[WORD_W-1:0]`. Word k (k = 0 for the device nearest the host) sits at `words_o[k*WORD_W +: WORD_W]`, MSB first.
- R6: `sdo_i` is sampled at each `sck_o` rising edge. Each `sck_o` level lasts `SCK_DIV` clock cycles, so data that changes after a falling edge is captured correctly.
- R7: `valid_o` is a one-cycle pulse that coincides with `cnv_o` going low. Both occur on the same edge as the final `sck_o` falling edge.
- R8: If no completion flag arrives in flag mode, `cnv_o` stays high for exactly `BUSY_TIMEOUT+2` cycles. At the end `timeout_o` pulses for one cycle, `cnv_o` drops, and `valid_o` does not pulse.
- R9: A `start_i` pulse is dropped while a cycle is in progress, and also while fewer than `MIN_CYCLE` cycles have passed since the last `cnv_o` rising edge. No `cnv_o` rise follows a dropped pulse.
- R10: `sck_o` falls only while `cnv_o` was high in the previous cycle, so no clock edge reaches the chain outside a conversion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion and readback cycle |
| busy_mode_i | input | 1 | Completion option latched at start: 0 timed, 1 flag |
| sdo_i | input | 1 | Serial data from the last device in the chain |
| cnv_o | output | 1 | Convert strobe to all devices |
| sck_o | output | 1 | Serial clock to all devices |
| words_o | output | NUM_DEV*WORD_W | Per-device results, device nearest the host in the low word |
| valid_o | output | 1 | One-cycle pulse: `words_o` updated |
| timeout_o | output | 1 | One-cycle pulse: completion flag never arrived |

## Verification
The bench models the chain as a shift stream. The stream picks its completion option from `sck_o` at the strobe edge and changes data one cycle after each clock fall. A controller that forgot to drop the flag bit in flag mode would return every word shifted by one bit. Swapping the word order would put the far device in the low word. An off-by-one clock count shows up both in the rising-edge tally and in corrupted LSBs. Starting too early in timed mode would sample zeros before the data loads. The bench also withholds the completion flag to measure the exact strobe length before timeout. It fires start pulses mid-read and just after a read to catch a controller that queues them or ignores the minimum cycle gap.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CNV,
    ST_WAIT,
    ST_SHIFT
  } rd_state_e;
endpackage

// File: rtl/chain_timer.sv
module chain_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= W'(RST_VAL);
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q >= limit_i);
endmodule

// File: rtl/chain_sck_gen.sv
module chain_sck_gen #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          last;

  assign last = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (last) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // strobes mark the cycle whose closing edge moves sck
  assign rise_o = en_i & last & ~sck_q;
  assign fall_o = en_i & last & sck_q;
  assign sck_o  = sck_q;
endmodule

// File: rtl/chain_deser.sv
module chain_deser #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          shift_i,
  input  logic                          bit_i,
  output logic [NUM_WORDS*WORD_W-1:0]   words_o
);
  localparam int TOTAL = NUM_WORDS * WORD_W;

  logic [TOTAL-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shreg_q <= '0;
    else if (clr_i)   shreg_q <= '0;
    else if (shift_i) shreg_q <= {shreg_q[TOTAL-2:0], bit_i};
  end

  // first word received lands in the low slot
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_split
    assign words_o[k*WORD_W +: WORD_W] = shreg_q[TOTAL-1-k*WORD_W -: WORD_W];
  end
endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader
  import chain_adc_pkg::*;
#(
  parameter int NUM_DEV      = 4,
  parameter int WORD_W       = 16,
  parameter int SCK_DIV      = 2,
  parameter int CONV_CYC     = 150,
  parameter int BUSY_TIMEOUT = 400,
  parameter int MIN_CYCLE    = 600
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      busy_mode_i,
  input  logic                      sdo_i,
  output logic                      cnv_o,
  output logic                      sck_o,
  output logic [NUM_DEV*WORD_W-1:0] words_o,
  output logic                      valid_o,
  output logic                      timeout_o
);
  localparam int TOTAL    = NUM_DEV * WORD_W;
  localparam int CW       = $clog2(TOTAL + 2);
  localparam int WAIT_MAX = (CONV_CYC > BUSY_TIMEOUT) ? CONV_CYC : BUSY_TIMEOUT;
  localparam int TW       = $clog2(WAIT_MAX + 1);
  localparam int MW       = $clog2(MIN_CYCLE + 1);

  rd_state_e        state_q;
  logic             mode_q, cnv_q, valid_q, tmo_q;
  logic [CW-1:0]    clk_cnt_q;
  logic [TOTAL-1:0] words_q;
  logic [TOTAL-1:0] deser_words;
  logic [TW-1:0]    wait_lim;
  logic             wait_hit, gap_ok;
  logic             gen_sck, sck_rise, sck_fall;
  logic             last_clk, take_bit;

  assign wait_lim = mode_q ? TW'(BUSY_TIMEOUT) : TW'(CONV_CYC);
  assign last_clk = (clk_cnt_q == (mode_q ? CW'(TOTAL) : CW'(TOTAL - 1)));
  // flag mode: first sampled bit is the completion flag itself
  assign take_bit = sck_rise & ~(mode_q & (clk_cnt_q == '0));

  chain_timer #(.W(MW), .RST_VAL(MIN_CYCLE)) i_gap_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_SETUP),
    .limit_i (MW'(MIN_CYCLE)),
    .hit_o   (gap_ok)
  );

  chain_timer #(.W(TW), .RST_VAL(0)) i_wait_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_CNV),
    .limit_i (wait_lim),
    .hit_o   (wait_hit)
  );

  chain_sck_gen #(.DIV(SCK_DIV)) i_sck_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_SHIFT),
    .sck_o  (gen_sck),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  chain_deser #(.WORD_W(WORD_W), .NUM_WORDS(NUM_DEV)) i_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_WAIT),
    .shift_i (take_bit),
    .bit_i   (sdo_i),
    .words_o (deser_words)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mode_q    <= 1'b0;
      cnv_q     <= 1'b0;
      valid_q   <= 1'b0;
      tmo_q     <= 1'b0;
      clk_cnt_q <= '0;
      words_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      tmo_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && gap_ok) begin
            mode_q  <= busy_mode_i;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          cnv_q   <= 1'b1;
          state_q <= ST_CNV;
        end
        ST_CNV: state_q <= ST_WAIT;
        ST_WAIT: begin
          clk_cnt_q <= '0;
          if (mode_q) begin
            if (sdo_i) state_q <= ST_SHIFT;
            else if (wait_hit) begin
              cnv_q   <= 1'b0;
              tmo_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else if (wait_hit) begin
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (sck_fall) begin
            clk_cnt_q <= clk_cnt_q + 1'b1;
            if (last_clk) begin
              cnv_q   <= 1'b0;
              valid_q <= 1'b1;
              words_q <= deser_words;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sck_o     = (state_q == ST_SETUP || state_q == ST_CNV) ? mode_q : gen_sck;
  assign cnv_o     = cnv_q;
  assign valid_o   = valid_q;
  assign timeout_o = tmo_q;
  assign words_o   = words_q;
endmodule

// File: rtl/chain_adc_reader_chk.sv
module chain_adc_reader_chk #(
  parameter int MIN_CYCLE = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cnv_o,
  input logic sck_o,
  input logic valid_o,
  input logic timeout_o
);
  logic cnv_d;
  int   gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnv_d <= 1'b0;
      gap_q <= MIN_CYCLE;
    end else begin
      cnv_d <= cnv_o;
      if (cnv_o && !cnv_d)      gap_q <= 1;
      else if (gap_q < MIN_CYCLE) gap_q <= gap_q + 1;
    end
  end

  assert_sck_held_at_cnv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> $stable(sck_o));

  assert_valid_ends_cnv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!cnv_o && $past(cnv_o)));

  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_timeout_ends_cnv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!cnv_o && $past(cnv_o)));

  assert_one_outcome_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_o, timeout_o}));

  assert_min_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnv_o && !cnv_d) |-> (gap_q >= MIN_CYCLE));

  assert_sck_fall_in_cnv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> $past(cnv_o));
endmodule

bind chain_adc_reader chain_adc_reader_chk #(.MIN_CYCLE(MIN_CYCLE)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnv_o     (cnv_o),
  .sck_o     (sck_o),
  .valid_o   (valid_o),
  .timeout_o (timeout_o)
);

// File: tb/test_chain_adc_reader.sv
`timescale 1ns/1ps
module test_chain_adc_reader;
  localparam int N     = 3;
  localparam int WW    = 16;
  localparam int TOTAL = N * WW;
  localparam int DIV   = 2;
  localparam int CONV  = 20;
  localparam int TMO   = 60;
  localparam int MINC  = 300;
  localparam int CONV_MODEL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy_mode = 1'b0;
  logic sdo;
  logic cnv, sck, valid, tmo;
  logic [TOTAL-1:0] words;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  chain_adc_reader #(
    .NUM_DEV(N), .WORD_W(WW), .SCK_DIV(DIV), .CONV_CYC(CONV),
    .BUSY_TIMEOUT(TMO), .MIN_CYCLE(MINC)
  ) i_chain_adc_reader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_mode_i(busy_mode),
    .sdo_i(sdo), .cnv_o(cnv), .sck_o(sck), .words_o(words),
    .valid_o(valid), .timeout_o(tmo)
  );

  // chain model: option picked from sck at strobe edge, shifts one cycle after sck falls
  logic             conv_en = 1'b1;
  logic [TOTAL-1:0] dev_data = '0;
  logic [TOTAL:0]   stream = '0;
  logic             loaded = 1'b0;
  logic             busy_sel = 1'b0;
  logic             sck_d = 1'b0, cnv_d = 1'b0, seen_rise = 1'b0;
  int               conv_t = 0, cnv_hi = 0, rise_total = 0, cyc = 0, rise_cyc0 = 0, first_gap = 0;

  assign sdo = loaded & stream[TOTAL];

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    sck_d <= sck;
    cnv_d <= cnv;
    if (cnv && !cnv_d) begin
      busy_sel  <= sck;
      conv_t    <= CONV_MODEL;
      cnv_hi    <= 1;
      rise_cyc0 <= cyc;
      seen_rise <= 1'b0;
    end else if (cnv) cnv_hi <= cnv_hi + 1;
    if (!cnv) loaded <= 1'b0;
    else if (conv_t == 1) begin
      conv_t <= 0;
      if (conv_en) begin
        loaded <= 1'b1;
        stream <= busy_sel ? {1'b1, dev_data} : {dev_data, 1'b0};
      end
    end else if (conv_t > 1) conv_t <= conv_t - 1;
    else if (loaded && sck_d && !sck) stream <= stream << 1;
    if (sck && !sck_d && cnv) begin
      rise_total <= rise_total + 1;
      if (!seen_rise) begin
        seen_rise <= 1'b1;
        first_gap <= cyc - rise_cyc0;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic             got_v, got_t, cnv_at_end;
  logic [TOTAL-1:0] got_w;

  task automatic wait_outcome();
    got_v = 1'b0; got_t = 1'b0; cnv_at_end = 1'b1; got_w = '0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (valid || tmo) begin
        got_v = valid; got_t = tmo; got_w = words; cnv_at_end = cnv;
        break;
      end
    end
  endtask

  task automatic pulse_start(input logic bm);
    @(negedge clk);
    start = 1'b1; busy_mode = bm;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 cnv", cnv, 0);
    chk("R1 sck", sck, 0);
    chk("R1 valid", valid, 0);
    chk("R1 timeout", tmo, 0);
  endtask

  task automatic t_read(input logic bm, input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    int r0;
    repeat (MINC + 10) @(negedge clk);
    dev_data = {a, b, c};
    conv_en  = 1'b1;
    r0 = rise_total;
    pulse_start(bm);
    wait_outcome();
    chk("R7 valid pulse", got_v, 1);
    chk("R7 cnv low with valid", cnv_at_end, 0);
    chk("R2 sck level at cnv rise", busy_sel, bm);
    chk("R5 nearest device in low word", got_w[15:0], a);
    chk("R5 R6 all words", got_w, {c, b, a});
    if (bm) chk("R4 clock count flag mode", rise_total - r0, TOTAL + 1);
    else begin
      chk("R3 clock count timed mode", rise_total - r0, TOTAL);
      chk("R3 wait before first clock", first_gap >= CONV, 1);
    end
    @(negedge clk);
    chk("R7 valid one cycle", valid, 0);
    chk("R10 sck idle after read", sck, 0);
  endtask

  task automatic t_timeout();
    repeat (MINC + 10) @(negedge clk);
    conv_en = 1'b0;
    pulse_start(1'b1);
    wait_outcome();
    chk("R8 timeout pulse", got_t, 1);
    chk("R8 no valid", got_v, 0);
    chk("R8 cnv low at timeout", cnv_at_end, 0);
    chk("R8 cnv high length", cnv_hi, TMO + 2);
    @(negedge clk);
    chk("R8 timeout one cycle", tmo, 0);
    conv_en = 1'b1;
  endtask

  task automatic t_refuse();
    int hi;
    repeat (MINC + 10) @(negedge clk);
    dev_data = {16'h1357, 16'h2468, 16'h9ABC};
    pulse_start(1'b0);
    repeat (60) @(negedge clk);
    pulse_start(1'b1);
    wait_outcome();
    chk("R9 read unaffected by mid-cycle start", got_w, {16'h9ABC, 16'h2468, 16'h1357});
    pulse_start(1'b0);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cnv) hi++;
    end
    chk("R9 early start dropped", hi, 0);
    chk("R9 mid-cycle start not queued", valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_read(1'b0, 16'hA5C3, 16'h0001, 16'hFFFE);
    t_read(1'b0, 16'h8000, 16'h5555, 16'h0000);
    t_read(1'b1, 16'h7FFF, 16'hAAAA, 16'h8001);
    t_read(1'b1, 16'h0F0F, 16'hC001, 16'h1234);
    t_timeout();
    t_refuse();
    t_read(1'b0, 16'hBEEF, 16'h4321, 16'h00FF);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule